// File: doc/BRIEF.md
# Vector Block Header Parser

This parser sits at the front of a vector instruction block. It takes 16-bit instruction parcels one at a time over a valid/ready handshake. The first parcel is the block header. A 2-bit prefix mode field in the header sets how many parcels follow, and the parser collects exactly that many. Once it has them, it presents the decoded prefix material on its outputs and raises a one-cycle done strobe.

A short prefix is one parcel. It holds a 5-bit activation offset in bits 15:11 and an 11-bit opaque prefix field in bits 10:0. A long extension is one further 16-bit parcel. It is passed on as an opaque vector-length update request, which the consumer applies as an implicit set-vector-length step ahead of the block's first instruction. The twin mode adds a second short prefix after the short/long pair, with its own offset. The parser does not interpret the prefix fields. It does not decode the extended format and it does not perform the vector-length update.

After the last expected parcel, the parser stops accepting input and holds its outputs until reset. It uses states ST_HEAD, ST_SHORT0, ST_LONG, ST_SHORT1, ST_FIN, ST_HOLD and ST_BAD, with these transitions:

- ST_HEAD goes to ST_BAD on a bad key, to ST_FIN in mode 00, and to ST_SHORT0 otherwise.
- ST_SHORT0 goes to ST_FIN in mode 01, and to ST_LONG otherwise.
- ST_LONG goes to ST_FIN in mode 10, and to ST_SHORT1 otherwise.
- ST_SHORT1 goes to ST_FIN.
- ST_FIN goes to ST_HOLD after one cycle.
- ST_HOLD and ST_BAD stay where they are until reset.

Each transition out of ST_HEAD, ST_SHORT0, ST_LONG and ST_SHORT1 happens only on an accepted parcel.

Top module: `vpfx_hdr_parser`

## Requirements
- R1: After reset, parcel_ready_o is 1 and done_o, err_o, every valid flag, mode_o and blk_len_o are 0. A reset in the middle of a block returns the parser to this state.
- R2: A header is recognised when its bits 6:0 equal 1111111. Header bits 8:7 then appear on mode_o and header bits 14:12 on blk_len_o. Bits 15 and 11:9 have no effect.
- R3: In mode 00 (extended format), done_o is 1 in the cycle after the header is accepted, and no valid flag is set.
- R4: In mode 01, exactly one parcel follows the header. pfx0_offs_o shows its bits 15:11, pfx0_bits_o shows its bits 10:0, and pfx0_valid_o and done_o both rise in the cycle after that parcel is accepted.
- R5: In mode 10, two parcels follow: first the short prefix (laid out as in R4), then the long extension. The extension appears whole on vl_upd_bits_o with vl_upd_valid_o set. The vector-length update request is only ever valid alongside a valid first prefix.
- R6: In mode 11, three parcels follow: short prefix, long extension, then a second short prefix. The second prefix's bits 15:11 and 10:0 appear on pfx1_offs_o and pfx1_bits_o with pfx1_valid_o set. The second prefix is only ever valid together with the extension.
- R7: A parcel is consumed only in a cycle where parcel_valid_i and parcel_ready_o are both 1. Cycles with parcel_valid_i low change no output field, whatever is on parcel_i.
- R8: From the cycle in which done_o is 1 until reset, parcel_ready_o is 0. Any parcels offered during this time leave every output field unchanged.
- R9: A header whose bits 6:0 are not 1111111 sets err_o and drops parcel_ready_o until reset. It never sets done_o or any valid flag, and it leaves mode_o and blk_len_o at 0.
- R10: done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also re-arms the parser for the next block |
| parcel_i | input | 16 | Incoming instruction parcel |
| parcel_valid_i | input | 1 | parcel_i holds a parcel |
| parcel_ready_o | output | 1 | Parser will take a parcel this cycle |
| done_o | output | 1 | One-cycle pulse: all parcels of the header group have been taken |
| err_o | output | 1 | Header key mismatch; held until reset |
| mode_o | output | 2 | Prefix mode from the header |
| blk_len_o | output | 3 | Block length field from the header, in 16-bit units |
| pfx0_valid_o | output | 1 | First short prefix captured |
| pfx0_offs_o | output | 5 | Activation offset of the first prefix |
| pfx0_bits_o | output | 11 | Opaque field of the first prefix |
| vl_upd_valid_o | output | 1 | Long extension captured (vector-length update request) |
| vl_upd_bits_o | output | 16 | Opaque long extension |
| pfx1_valid_o | output | 1 | Second short prefix captured |
| pfx1_offs_o | output | 5 | Activation offset of the second prefix |
| pfx1_bits_o | output | 11 | Opaque field of the second prefix |

## Verification
The table-driven walk covers one header for each of the four modes, plus one twin-mode header with every reserved bit set and a length of seven. Together they separate the parcel counts 0, 1, 2 and 3 and show that reserved bits do not leak into the mode or length. The prefix parcels use all-ones and all-zeros offsets and distinct bit patterns, so a swapped slot or a shifted field boundary gives a wrong value.

Further patterns each target one behaviour:
- A twin-mode block with idle gaps, and junk on the data bus during them, separates handshake-qualified capture from blind capture.
- A header with a wrong key separates the error path from a normal start.
- Parcels offered after completion show that the parser no longer accepts input.
- A reset in the middle of a block shows that the parser re-arms cleanly.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;

    localparam int PARCEL_W  = 16;
    localparam int KEY_W     = 7;
    localparam logic [KEY_W-1:0] HDR_KEY = {KEY_W{1'b1}};
    localparam int MODE_W    = 2;
    localparam int MODE_LSB  = 7;
    localparam int LEN_W     = 3;
    localparam int LEN_LSB   = 12;
    localparam int OFFS_W    = 5;
    localparam int PFX_W     = PARCEL_W - OFFS_W;
    localparam int NUM_SLOTS = 3;
    localparam int SLOT_P0   = 0;
    localparam int SLOT_EXT  = 1;
    localparam int SLOT_P1   = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_EXTFMT = 2'b00,
        PM_SHORT  = 2'b01,
        PM_LONG   = 2'b10,
        PM_TWIN   = 2'b11
    } pmode_e;

    typedef enum logic [2:0] {
        ST_HEAD,
        ST_SHORT0,
        ST_LONG,
        ST_SHORT1,
        ST_FIN,
        ST_HOLD,
        ST_BAD
    } pstate_e;

endpackage

// File: rtl/vpfx_hdr_decode.sv
module vpfx_hdr_decode
    import vpfx_pkg::*;
(
    input  logic [KEY_W-1:0]  key_i,
    input  logic [MODE_W-1:0] mode_bits_i,
    input  logic [LEN_W-1:0]  len_bits_i,
    output logic              key_ok_o,
    output pmode_e            mode_o,
    output logic [LEN_W-1:0]  len_o
);

    always_comb begin
        key_ok_o = (key_i == HDR_KEY);
        mode_o   = pmode_e'(mode_bits_i);
        len_o    = len_bits_i;
    end

endmodule

// File: rtl/vpfx_slot.sv
module vpfx_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         vld_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o   <= '0;
            vld_o <= 1'b0;
        end else if (load_i) begin
            q_o   <= d_i;
            vld_o <= 1'b1;
        end
    end

endmodule

// File: rtl/vpfx_fsm.sv
module vpfx_fsm
    import vpfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic                 key_ok_i,
    input  pmode_e               hdr_mode_i,
    input  pmode_e               blk_mode_i,
    output logic                 ready_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 ld_hdr_o,
    output logic [NUM_SLOTS-1:0] ld_slot_o
);

    pstate_e state_q;
    pstate_e state_d;
    logic    take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HEAD: begin
                if (take) begin
                    if (!key_ok_i)                   state_d = ST_BAD;
                    else if (hdr_mode_i == PM_EXTFMT) state_d = ST_FIN;
                    else                              state_d = ST_SHORT0;
                end
            end
            ST_SHORT0: begin
                if (take) state_d = (blk_mode_i == PM_SHORT) ? ST_FIN : ST_LONG;
            end
            ST_LONG: begin
                if (take) state_d = (blk_mode_i == PM_LONG) ? ST_FIN : ST_SHORT1;
            end
            ST_SHORT1: begin
                if (take) state_d = ST_FIN;
            end
            ST_FIN:  state_d = ST_HOLD;
            ST_HOLD: state_d = ST_HOLD;
            ST_BAD:  state_d = ST_BAD;
            default: state_d = ST_BAD;
        endcase
    end

    // outputs
    always_comb begin
        ready_o   = 1'b0;
        done_o    = 1'b0;
        err_o     = 1'b0;
        ld_hdr_o  = 1'b0;
        ld_slot_o = '0;
        unique case (state_q)
            ST_HEAD:   ready_o = 1'b1;
            ST_SHORT0: ready_o = 1'b1;
            ST_LONG:   ready_o = 1'b1;
            ST_SHORT1: ready_o = 1'b1;
            ST_FIN:    done_o  = 1'b1;
            ST_HOLD:   ready_o = 1'b0;
            ST_BAD:    err_o   = 1'b1;
            default:   err_o   = 1'b1;
        endcase
        take = valid_i && ready_o;
        ld_hdr_o            = take && (state_q == ST_HEAD) && key_ok_i;
        ld_slot_o[SLOT_P0]  = take && (state_q == ST_SHORT0);
        ld_slot_o[SLOT_EXT] = take && (state_q == ST_LONG);
        ld_slot_o[SLOT_P1]  = take && (state_q == ST_SHORT1);
    end

endmodule

// File: rtl/vpfx_hdr_parser.sv
module vpfx_hdr_parser
    import vpfx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PARCEL_W-1:0] parcel_i,
    input  logic                parcel_valid_i,
    output logic                parcel_ready_o,
    output logic                done_o,
    output logic                err_o,
    output logic [MODE_W-1:0]   mode_o,
    output logic [LEN_W-1:0]    blk_len_o,
    output logic                pfx0_valid_o,
    output logic [OFFS_W-1:0]   pfx0_offs_o,
    output logic [PFX_W-1:0]    pfx0_bits_o,
    output logic                vl_upd_valid_o,
    output logic [PARCEL_W-1:0] vl_upd_bits_o,
    output logic                pfx1_valid_o,
    output logic [OFFS_W-1:0]   pfx1_offs_o,
    output logic [PFX_W-1:0]    pfx1_bits_o
);

    logic                 key_ok;
    pmode_e               hdr_mode;
    logic [LEN_W-1:0]     hdr_len;
    pmode_e               mode_q;
    logic [LEN_W-1:0]     len_q;
    logic                 ld_hdr;
    logic [NUM_SLOTS-1:0] ld_slot;
    logic [PARCEL_W-1:0]  slot_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_v;

    vpfx_hdr_decode u_dec (
        .key_i       (parcel_i[KEY_W-1:0]),
        .mode_bits_i (parcel_i[MODE_LSB +: MODE_W]),
        .len_bits_i  (parcel_i[LEN_LSB +: LEN_W]),
        .key_ok_o    (key_ok),
        .mode_o      (hdr_mode),
        .len_o       (hdr_len)
    );

    vpfx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (parcel_valid_i),
        .key_ok_i   (key_ok),
        .hdr_mode_i (hdr_mode),
        .blk_mode_i (mode_q),
        .ready_o    (parcel_ready_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .ld_hdr_o   (ld_hdr),
        .ld_slot_o  (ld_slot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_EXTFMT;
            len_q  <= '0;
        end else if (ld_hdr) begin
            mode_q <= hdr_mode;
            len_q  <= hdr_len;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        vpfx_slot #(.W(PARCEL_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (ld_slot[g]),
            .d_i    (parcel_i),
            .q_o    (slot_q[g]),
            .vld_o  (slot_v[g])
        );
    end

    always_comb begin
        mode_o         = mode_q;
        blk_len_o      = len_q;
        pfx0_valid_o   = slot_v[SLOT_P0];
        pfx0_offs_o    = slot_q[SLOT_P0][PARCEL_W-1 -: OFFS_W];
        pfx0_bits_o    = slot_q[SLOT_P0][PFX_W-1:0];
        vl_upd_valid_o = slot_v[SLOT_EXT];
        vl_upd_bits_o  = slot_q[SLOT_EXT];
        pfx1_valid_o   = slot_v[SLOT_P1];
        pfx1_offs_o    = slot_q[SLOT_P1][PARCEL_W-1 -: OFFS_W];
        pfx1_bits_o    = slot_q[SLOT_P1][PFX_W-1:0];
    end

endmodule

// File: rtl/vpfx_hdr_parser_chk.sv
module vpfx_hdr_parser_chk
    import vpfx_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [PARCEL_W-1:0] parcel_i,
    input logic                parcel_valid_i,
    input logic                parcel_ready_o,
    input logic                done_o,
    input logic                err_o,
    input logic [MODE_W-1:0]   mode_o,
    input logic [LEN_W-1:0]    blk_len_o,
    input logic                pfx0_valid_o,
    input logic [OFFS_W-1:0]   pfx0_offs_o,
    input logic [PFX_W-1:0]    pfx0_bits_o,
    input logic                vl_upd_valid_o,
    input logic [PARCEL_W-1:0] vl_upd_bits_o,
    input logic                pfx1_valid_o,
    input logic [OFFS_W-1:0]   pfx1_offs_o,
    input logic [PFX_W-1:0]    pfx1_bits_o
);

    logic [PARCEL_W-1:0] unused_parcel;
    assign unused_parcel = parcel_i;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_no_ready_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !parcel_ready_o);

    assert_frozen_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !parcel_ready_o |=> $stable({mode_o, blk_len_o, pfx0_valid_o, pfx0_offs_o, pfx0_bits_o,
                                     vl_upd_valid_o, vl_upd_bits_o, pfx1_valid_o, pfx1_offs_o,
                                     pfx1_bits_o, parcel_ready_o, err_o}));

    assert_idle_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !parcel_valid_i |=> $stable({mode_o, blk_len_o, pfx0_valid_o, pfx0_offs_o, pfx0_bits_o,
                                     vl_upd_valid_o, vl_upd_bits_o, pfx1_valid_o, pfx1_offs_o,
                                     pfx1_bits_o, err_o}));

    assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !(pfx0_valid_o || vl_upd_valid_o || pfx1_valid_o || done_o || parcel_ready_o));

    assert_extfmt_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_o == 2'b00) |-> !pfx0_valid_o);

    assert_short_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pfx0_valid_o) && mode_o == 2'b01) |-> done_o);

    assert_ext_needs_p0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vl_upd_valid_o |-> pfx0_valid_o);

    assert_p1_needs_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pfx1_valid_o |-> vl_upd_valid_o);

endmodule

bind vpfx_hdr_parser vpfx_hdr_parser_chk chk_i (.*);

// File: tb/vpfx_hdr_parser_tb_top.sv
module vpfx_hdr_parser_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] parcel_i = '0;
    logic        parcel_valid_i = 1'b0;
    logic        parcel_ready_o, done_o, err_o;
    logic [1:0]  mode_o;
    logic [2:0]  blk_len_o;
    logic        pfx0_valid_o, vl_upd_valid_o, pfx1_valid_o;
    logic [4:0]  pfx0_offs_o, pfx1_offs_o;
    logic [10:0] pfx0_bits_o, pfx1_bits_o;
    logic [15:0] vl_upd_bits_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vpfx_hdr_parser dut_i (
        .clk(clk), .rst_n(rst_n), .parcel_i(parcel_i), .parcel_valid_i(parcel_valid_i),
        .parcel_ready_o(parcel_ready_o), .done_o(done_o), .err_o(err_o),
        .mode_o(mode_o), .blk_len_o(blk_len_o),
        .pfx0_valid_o(pfx0_valid_o), .pfx0_offs_o(pfx0_offs_o), .pfx0_bits_o(pfx0_bits_o),
        .vl_upd_valid_o(vl_upd_valid_o), .vl_upd_bits_o(vl_upd_bits_o),
        .pfx1_valid_o(pfx1_valid_o), .pfx1_offs_o(pfx1_offs_o), .pfx1_bits_o(pfx1_bits_o)
    );

    localparam int NV = 5;
    localparam logic [15:0] T_HDR [NV] = '{16'h207F, 16'h50FF, 16'h117F, 16'hFFFF, 16'h01FF};
    localparam logic [15:0] T_P0  [NV] = '{16'h0000, 16'hA9C3, 16'h0805, 16'h1234, 16'h0000};
    localparam logic [15:0] T_EXT [NV] = '{16'h0000, 16'h0000, 16'hBEEF, 16'h5678, 16'hFFFF};
    localparam logic [15:0] T_P1  [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'hF800, 16'h07FF};

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        parcel_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [15:0] p);
        @(negedge clk);
        parcel_i = p;
        parcel_valid_i = 1'b1;
        @(posedge clk);
    endtask

    task automatic check_idle_state(input string req);
        chk(req, "ready", parcel_ready_o, 1);
        chk(req, "done", done_o, 0);
        chk(req, "err", err_o, 0);
        chk(req, "valids", {pfx0_valid_o, vl_upd_valid_o, pfx1_valid_o}, 0);
        chk(req, "mode", mode_o, 0);
        chk(req, "len", blk_len_o, 0);
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // expected fields of a finished block, derived from the parcels
    task automatic check_fields(input logic [15:0] h, input logic [15:0] a,
                                input logic [15:0] e, input logic [15:0] b);
        logic [1:0] m;
        int n;
        string rq;
        m  = h[8:7];
        n  = int'(m);
        rq = mode_req(m);
        chk("R2", "mode", mode_o, m);
        chk("R2", "len", blk_len_o, h[14:12]);
        chk(rq, "pfx0_valid", pfx0_valid_o, (n >= 1) ? 1 : 0);
        chk(rq, "vl_upd_valid", vl_upd_valid_o, (n >= 2) ? 1 : 0);
        chk(rq, "pfx1_valid", pfx1_valid_o, (n == 3) ? 1 : 0);
        if (n >= 1) begin
            chk("R4", "pfx0_offs", pfx0_offs_o, a[15:11]);
            chk("R4", "pfx0_bits", pfx0_bits_o, a[10:0]);
        end
        if (n >= 2) chk("R5", "vl_upd_bits", vl_upd_bits_o, e);
        if (n == 3) begin
            chk("R6", "pfx1_offs", pfx1_offs_o, b[15:11]);
            chk("R6", "pfx1_bits", pfx1_bits_o, b[10:0]);
        end
        chk("R9", "err", err_o, 0);
    endtask

    task automatic run_block(input logic [15:0] h, input logic [15:0] a,
                             input logic [15:0] e, input logic [15:0] b);
        int n;
        n = int'(h[8:7]);
        do_reset();
        put(h);
        if (n >= 1) put(a);
        if (n >= 2) put(e);
        if (n >= 3) put(b);
        @(negedge clk);
        parcel_valid_i = 1'b0;
        chk(mode_req(h[8:7]), "done after last parcel", done_o, 1);
        chk("R8", "ready at done", parcel_ready_o, 0);
        check_fields(h, a, e, b);
        // R10: pulse drops; R8: extra parcels ignored
        put(16'h1111);
        put(16'hFFFF);
        @(negedge clk);
        parcel_valid_i = 1'b0;
        chk("R10", "done pulse ended", done_o, 0);
        chk("R8", "ready stays low", parcel_ready_o, 0);
        check_fields(h, a, e, b);
    endtask

    task automatic gap(input int k, input logic p0v, input logic extv);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            parcel_valid_i = 1'b0;
            parcel_i = 16'hDEAD;
            chk("R7", "ready during gap", parcel_ready_o, 1);
            chk("R7", "no done during gap", done_o, 0);
            chk("R7", "pfx0_valid during gap", pfx0_valid_o, p0v);
            chk("R7", "vl_upd_valid during gap", vl_upd_valid_o, extv);
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        check_idle_state("R1");

        // table walk over all modes
        for (int v = 0; v < NV; v++) begin
            run_block(T_HDR[v], T_P0[v], T_EXT[v], T_P1[v]);
        end

        // R7: twin block with idle gaps and junk on the bus
        do_reset();
        put(16'h31FF);
        gap(3, 1'b0, 1'b0);
        put(16'h6A55);
        gap(2, 1'b1, 1'b0);
        put(16'hC3C3);
        gap(1, 1'b1, 1'b1);
        put(16'h9ABC);
        @(negedge clk);
        parcel_valid_i = 1'b0;
        chk("R7", "done after gapped block", done_o, 1);
        check_fields(16'h31FF, 16'h6A55, 16'hC3C3, 16'h9ABC);

        // R9: bad header key
        do_reset();
        put(16'h017E);
        @(negedge clk);
        parcel_valid_i = 1'b0;
        chk("R9", "err", err_o, 1);
        chk("R9", "ready", parcel_ready_o, 0);
        chk("R9", "done", done_o, 0);
        chk("R9", "valids", {pfx0_valid_o, vl_upd_valid_o, pfx1_valid_o}, 0);
        chk("R9", "mode", mode_o, 0);
        put(16'h00FF);
        put(16'h1234);
        @(negedge clk);
        parcel_valid_i = 1'b0;
        chk("R9", "err held", err_o, 1);
        chk("R9", "valids stay clear", {pfx0_valid_o, vl_upd_valid_o, pfx1_valid_o}, 0);
        chk("R9", "len untouched", blk_len_o, 0);

        // R1: reset in mid-block
        do_reset();
        put(16'hFFFF);
        put(16'h1234);
        @(negedge clk);
        parcel_valid_i = 1'b0;
        chk("R4", "pfx0 captured before abort", pfx0_valid_o, 1);
        do_reset();
        @(negedge clk);
        check_idle_state("R1");

        summary();
    end

endmodule